// File: doc/BRIEF.md
# Register-List Stack Pop Sequencer

This unit carries out a multi-cycle frame release. It takes a 5-bit frame-size immediate, a 12-bit register-selection mask, an optional return-register index and the current stack pointer, all captured on a start strobe. In its first busy cycle it moves the stack pointer past the local frame. It then reads one 32-bit word from memory for each selected register and writes that word into the register file. After each word it advances the stack pointer by four bytes.

In the return form the unit finishes by reading the named register and presenting its value as a new program-counter target. The register is read only after every load has been written, so a return register that was itself in the list yields its restored value. The memory side uses a request valid/ready handshake and a separate response-valid strobe. The unit waits in its load step for as long as the memory takes.

Top module: `frame_pop_seq`

## Requirements
- R1: After reset, `busy`, `done`, `mem_req_valid`, `rf_we` and `pc_valid` are all low, and they remain low while the unit is idle.
- R2: In the first busy cycle the stack pointer becomes `sp_in + imm_frame*4`. The immediate is treated as unsigned. The first memory read uses this address.
- R3: For every set mask bit the unit reads one word at the current stack pointer and writes it to a register. The stack pointer grows by 4 after each write. The final `sp_out` is `sp_in + imm_frame*4 + 4*n`, where n is the number of set bits.
- R4: Mask bit i selects register 20+i. Bits are served from bit 0 upward, so the k-th set bit (counting from 0) receives the word at `sp_in + imm_frame*4 + 4*k`.
- R5: In the return form (`ret_en`=1), `pc_valid` pulses together with `done`. `pc_target` equals the named register's content after all loads have been written.
- R6: With a memory that always accepts and answers in the same cycle, an operation keeps `busy` high for n+1 cycles in the plain form and n+3 cycles in the return form.
- R7: A read request holds its valid and address until it is accepted. A response that arrives one or more cycles after acceptance is written correctly. Results are the same as with a zero-wait memory.
- R8: `busy` stays high from the cycle after the start strobe to the end of the operation. `done` is high for exactly one cycle, the last busy cycle, and `busy` is low in the next cycle.
- R9: A start strobe, and any field values, presented while `busy` is high are ignored. The final registers, `sp_out` and `pc_target` depend only on the request that was accepted.
- R10: An empty mask issues no reads and no register writes. It only adjusts the stack pointer, and in the return form it also performs the jump.
- R11: Registers not selected by the mask keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| imm_frame | input | 5 | Frame size in words, added as imm*4 |
| reg_mask | input | 12 | Register selection, bit i selects register 20+i |
| ret_en | input | 1 | Select the return form |
| ret_reg | input | 5 | Register holding the return target |
| sp_in | input | 32 | Stack pointer at start |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| sp_out | output | 32 | Current / final stack pointer |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Read address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 5 | Register-file write index |
| rf_wdata | output | 32 | Register-file write data |
| rf_raddr | output | 5 | Register-file read index (return register) |
| rf_rdata | input | 32 | Register-file read data |
| pc_valid | output | 1 | Program-counter redirect strobe |
| pc_target | output | 32 | New program-counter value |

## Verification
The bench builds the unit with its default parameters: 32-bit data, a 12-bit mask and register base 20. With a 12-bit mask, all 4096 masks can be swept in the plain form against a zero-wait memory, with exact cycle counts. A spread of masks, immediates and return registers covers the return form, including return registers inside and outside the restored range. A toggling-ready, one-cycle-late memory then exercises the stall path. Start strobes with junk fields are injected during some operations.

// File: rtl/frame_pop_pkg.sv
package frame_pop_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADJ,
        ST_LOAD,
        ST_JRD,
        ST_JMP
    } pop_state_e;

    // Mask slot to register index lookup: slot i names register base+i.
    function automatic int unsigned slot_reg(input int unsigned slot,
                                             input int unsigned base);
        return base + slot;
    endfunction

endpackage

// File: rtl/pop_lowbit_pick.sv
module pop_lowbit_pick #(
    parameter int W  = 12,
    parameter int IW = 4
) (
    input  logic [W-1:0]  mask,
    output logic          any,
    output logic [IW-1:0] idx,
    output logic [W-1:0]  rest
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (mask[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end

    // Mask with the lowest set bit cleared.
    assign rest = mask & (mask - W'(1));
endmodule

// File: rtl/pop_sp_unit.sv
module pop_sp_unit #(
    parameter int DW        = 32,
    parameter int IMM_W     = 5,
    parameter int ADJ_SHIFT = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld,
    input  logic [DW-1:0]    sp_in,
    input  logic             adj,
    input  logic [IMM_W-1:0] imm,
    input  logic             step,
    output logic [DW-1:0]    sp_q
);
    localparam int STEP = DW / 8;

    always_ff @(posedge clk) begin
        if (rst) begin
            sp_q <= '0;
        end else if (ld) begin
            sp_q <= sp_in;
        end else if (adj) begin
            sp_q <= sp_q + (DW'(imm) << ADJ_SHIFT);
        end else if (step) begin
            sp_q <= sp_q + DW'(STEP);
        end
    end
endmodule

// File: rtl/frame_pop_seq.sv
module frame_pop_seq
    import frame_pop_pkg::*;
#(
    parameter int DW       = 32,
    parameter int MASK_W   = 12,
    parameter int IMM_W    = 5,
    parameter int REG_AW   = 5,
    parameter int REG_BASE = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [IMM_W-1:0]  imm_frame,
    input  logic [MASK_W-1:0] reg_mask,
    input  logic              ret_en,
    input  logic [REG_AW-1:0] ret_reg,
    input  logic [DW-1:0]     sp_in,
    output logic              busy,
    output logic              done,
    output logic [DW-1:0]     sp_out,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [DW-1:0]     mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [DW-1:0]     mem_rsp_data,
    output logic              rf_we,
    output logic [REG_AW-1:0] rf_waddr,
    output logic [DW-1:0]     rf_wdata,
    output logic [REG_AW-1:0] rf_raddr,
    input  logic [DW-1:0]     rf_rdata,
    output logic              pc_valid,
    output logic [DW-1:0]     pc_target
);
    localparam int SLOT_W = (MASK_W > 1) ? $clog2(MASK_W) : 1;

    typedef struct packed {
        logic [MASK_W-1:0] mask;
        logic              jmp;
        logic [REG_AW-1:0] jreg;
        logic [IMM_W-1:0]  imm;
    } pop_req_t;

    pop_state_e        st_q, st_d;
    pop_req_t          req_q;
    logic              pend_q;
    logic [DW-1:0]     tgt_q;
    logic              pick_any;
    logic [SLOT_W-1:0] pick_idx;
    logic [MASK_W-1:0] mask_rest;
    logic              launch, fire, got, last;

    pop_lowbit_pick #(.W(MASK_W), .IW(SLOT_W)) u_pick (
        .mask (req_q.mask),
        .any  (pick_any),
        .idx  (pick_idx),
        .rest (mask_rest)
    );

    assign launch        = (st_q == ST_IDLE) && start;
    assign mem_req_valid = (st_q == ST_LOAD) && !pend_q;
    assign fire          = mem_req_valid && mem_req_ready;
    assign got           = (st_q == ST_LOAD) && mem_rsp_valid && (pend_q || fire);
    assign last          = (mask_rest == '0);

    pop_sp_unit #(.DW(DW), .IMM_W(IMM_W), .ADJ_SHIFT(2)) u_sp (
        .clk   (clk),
        .rst   (rst),
        .ld    (launch),
        .sp_in (sp_in),
        .adj   (st_q == ST_ADJ),
        .imm   (req_q.imm),
        .step  (got),
        .sp_q  (sp_out)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (launch) st_d = ST_ADJ;
            ST_ADJ: begin
                if (pick_any)        st_d = ST_LOAD;
                else if (req_q.jmp)  st_d = ST_JRD;
                else                 st_d = ST_IDLE;
            end
            ST_LOAD: begin
                if (got && last) st_d = req_q.jmp ? ST_JRD : ST_IDLE;
            end
            ST_JRD:  st_d = ST_JMP;
            ST_JMP:  st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            req_q  <= '0;
            pend_q <= 1'b0;
            tgt_q  <= '0;
        end else begin
            st_q <= st_d;
            if (launch) begin
                req_q.mask <= reg_mask;
                req_q.jmp  <= ret_en;
                req_q.jreg <= ret_reg;
                req_q.imm  <= imm_frame;
            end else if (got) begin
                req_q.mask <= mask_rest;
            end
            if (got)       pend_q <= 1'b0;
            else if (fire) pend_q <= 1'b1;
            if (st_q == ST_JRD) tgt_q <= rf_rdata;
        end
    end

    assign busy         = (st_q != ST_IDLE);
    assign done         = ((st_q == ST_ADJ) && !pick_any && !req_q.jmp)
                        || (got && last && !req_q.jmp)
                        || (st_q == ST_JMP);
    assign mem_req_addr = sp_out;
    assign rf_we        = got;
    assign rf_waddr     = REG_AW'(slot_reg(32'(pick_idx), REG_BASE));
    assign rf_wdata     = mem_rsp_data;
    assign rf_raddr     = req_q.jreg;
    assign pc_valid     = (st_q == ST_JMP);
    assign pc_target    = tgt_q;
endmodule

// File: rtl/frame_pop_seq_chk.sv
module frame_pop_seq_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          busy,
    input logic          done,
    input logic [DW-1:0] sp_out,
    input logic          mem_req_valid,
    input logic          mem_req_ready,
    input logic [DW-1:0] mem_req_addr,
    input logic          rf_we,
    input logic          pc_valid
);
    localparam int STEP = DW / 8;

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_req_valid && !rf_we && !pc_valid));

    a_r8_done_in_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    a_r8_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

    a_r7_req_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    a_r3_step_after_write: assert property (@(posedge clk) disable iff (rst)
        rf_we |=> (sp_out == $past(sp_out) + DW'(STEP)));

    a_r5_pc_with_done: assert property (@(posedge clk) disable iff (rst)
        pc_valid |-> done);
endmodule

bind frame_pop_seq frame_pop_seq_chk #(.DW(DW)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .busy          (busy),
    .done          (done),
    .sp_out        (sp_out),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .rf_we         (rf_we),
    .pc_valid      (pc_valid)
);

// File: tb/frame_pop_seq_bench.sv
module frame_pop_seq_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [4:0]  imm_frame = '0;
    logic [11:0] reg_mask = '0;
    logic        ret_en = 1'b0;
    logic [4:0]  ret_reg = '0;
    logic [31:0] sp_in = '0;
    logic        busy, done, mem_req_valid, mem_req_ready, mem_rsp_valid;
    logic [31:0] sp_out, mem_req_addr, mem_rsp_data, rf_wdata, rf_rdata, pc_target;
    logic        rf_we, pc_valid;
    logic [4:0]  rf_waddr, rf_raddr;

    logic [31:0] rf [32];
    logic        stall = 1'b0;
    logic        rdy_tog = 1'b0;
    logic        rsp_q = 1'b0;
    logic [31:0] data_q = '0;
    int          wr_cnt = 0;
    int          n_chk = 0;
    int          n_fail = 0;
    int          cyc_total = 0;

    always #2.5 clk = ~clk;

    frame_pop_seq u_frame_pop_seq (
        .clk(clk), .rst(rst), .start(start), .imm_frame(imm_frame),
        .reg_mask(reg_mask), .ret_en(ret_en), .ret_reg(ret_reg), .sp_in(sp_in),
        .busy(busy), .done(done), .sp_out(sp_out),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .rf_we(rf_we), .rf_waddr(rf_waddr),
        .rf_wdata(rf_wdata), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
        .pc_valid(pc_valid), .pc_target(pc_target)
    );

    function automatic logic [31:0] memf(input logic [31:0] a);
        return {a[15:0] ^ 16'h5A3C, a[15:0]};
    endfunction

    // Memory model: zero-wait (same-cycle answer) or toggling ready with a one-cycle-late answer.
    assign mem_req_ready = stall ? rdy_tog : 1'b1;
    assign mem_rsp_valid = stall ? rsp_q : (mem_req_valid && mem_req_ready);
    assign mem_rsp_data  = stall ? data_q : memf(mem_req_addr);
    assign rf_rdata      = rf[rf_raddr];

    always @(posedge clk) begin
        rdy_tog <= stall ? ~rdy_tog : 1'b0;
        rsp_q   <= stall && mem_req_valid && mem_req_ready;
        data_q  <= memf(mem_req_addr);
        if (rf_we) begin
            rf[rf_waddr] <= rf_wdata;
            wr_cnt <= wr_cnt + 1;
        end
        cyc_total <= cyc_total + 1;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic run_op(input logic [4:0] imm, input logic [11:0] m, input bit jen,
                          input logic [4:0] jidx, input bit stl, input bit inject,
                          input logic [31:0] sp0);
        logic [31:0] init [32];
        logic [31:0] expv [32];
        logic [31:0] base;
        int n, k, cyc;
        bit seen;
        n = 0;
        base = sp0 + {25'd0, imm, 2'b00};
        @(negedge clk);
        stall = stl;
        for (int i = 0; i < 32; i++) begin
            init[i] = 32'hC0DE_0000 + i * 32'h0101;
            rf[i] = init[i];
            expv[i] = init[i];
        end
        k = 0;
        for (int i = 0; i < 12; i++) begin
            if (m[i]) begin
                expv[20 + i] = memf(base + 32'(4 * k));
                k++;
            end
        end
        n = k;
        wr_cnt = 0;
        start = 1'b1; imm_frame = imm; reg_mask = m; ret_en = jen; ret_reg = jidx; sp_in = sp0;
        cyc = 0;
        seen = 1'b0;
        while (!seen && cyc < 200) begin
            @(negedge clk);
            cyc++;
            if (cyc == 1) begin
                start = 1'b0;
                if (inject) begin
                    // R9: junk start while busy
                    start = 1'b1; imm_frame = ~imm; reg_mask = ~m; ret_en = ~jen;
                    ret_reg = jidx + 5'd3; sp_in = sp0 ^ 32'h00F0_0000;
                end
            end else if (cyc == 2) begin
                start = 1'b0;
            end
            chk(busy === 1'b1, "R8 busy during op", {31'd0, busy}, 32'd1);
            if (done === 1'b1) begin
                seen = 1'b1;
                if (jen) begin
                    chk(pc_valid === 1'b1, "R5 pc_valid with done", {31'd0, pc_valid}, 32'd1);
                    chk(pc_target === expv[jidx], "R5 pc_target", pc_target, expv[jidx]);
                end else begin
                    chk(pc_valid === 1'b0, "R5 no pc_valid in plain form", {31'd0, pc_valid}, 32'd0);
                end
            end
        end
        chk(seen, "R8 done seen", 32'(cyc), 32'd0);
        if (!stl) chk(cyc == (jen ? n + 3 : n + 1), "R6 cycle count", 32'(cyc), 32'(jen ? n + 3 : n + 1));
        else      chk(cyc >= (jen ? n + 3 : n + 1), "R7 stall not faster", 32'(cyc), 32'(jen ? n + 3 : n + 1));
        @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0, "R8 single done then idle", {30'd0, busy, done}, 32'd0);
        chk(sp_out === base + 32'(4 * n), "R2 R3 final sp", sp_out, base + 32'(4 * n));
        chk(wr_cnt == n, "R3 R10 write count", 32'(wr_cnt), 32'(n));
        for (int i = 0; i < 32; i++) begin
            if (i >= 20 && m[i - 20])
                chk(rf[i] === expv[i], stl ? "R7 R4 restored reg" : "R4 restored reg", rf[i], expv[i]);
            else
                chk(rf[i] === expv[i], "R11 untouched reg", rf[i], expv[i]);
        end
    endtask

    initial begin
        for (int i = 0; i < 32; i++) rf[i] = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(busy === 1'b0 && done === 1'b0 && mem_req_valid === 1'b0 && rf_we === 1'b0 && pc_valid === 1'b0,
            "R1 reset state", {27'd0, busy, done, mem_req_valid, rf_we, pc_valid}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(busy === 1'b0 && mem_req_valid === 1'b0, "R1 idle after reset", {30'd0, busy, mem_req_valid}, 32'd0);

        // R10: empty mask, both forms
        run_op(5'd0, 12'h000, 1'b0, 5'd0, 1'b0, 1'b0, 32'h0000_4000);
        run_op(5'd31, 12'h000, 1'b1, 5'd7, 1'b0, 1'b0, 32'h0000_4000);

        // R2 R3 R4 R6: every mask, plain form, zero-wait memory
        for (int m = 0; m < 4096; m++) begin
            run_op(5'((m * 7) % 32), 12'(m), 1'b0, 5'd0, 1'b0,
                   ($countones(12'(m)) >= 2) && (m % 97 == 5), 32'h0001_0000 + 32'(m * 16));
        end

        // R5: return form, return register inside and outside the restored range
        for (int k = 0; k < 256; k++) begin
            run_op(5'(k % 32), 12'((k * 17) % 4096), 1'b1, 5'((k * 5 + 20) % 32), 1'b0,
                   (k % 11 == 3) && ($countones(12'((k * 17) % 4096)) >= 2), 32'h0008_0000 + 32'(k * 64));
        end
        run_op(5'd3, 12'hFFF, 1'b1, 5'd31, 1'b0, 1'b0, 32'h0002_0000);
        run_op(5'd3, 12'h001, 1'b1, 5'd20, 1'b0, 1'b0, 32'h0002_0000);

        // R7: toggling ready, late responses
        for (int k = 0; k < 96; k++) begin
            run_op(5'((k * 3) % 32), 12'((k * 37 + 1) % 4096), k[0], 5'((k + 18) % 32), 1'b1,
                   (k % 7 == 2) && ($countones(12'((k * 37 + 1) % 4096)) >= 2), 32'h000C_0000 + 32'(k * 128));
        end
        finish_run();
    end

    always @(negedge clk) begin
        if (cyc_total > 190000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<=190000", cyc_total);
            finish_run();
        end
    end
endmodule